// File: doc/BRIEF.md
# Inter-port mailbox interrupt logic

This block raises and drops the message-passing interrupts of a two-port shared memory. Two addresses at the top of the address space act as mailboxes, one per port. When one port writes its partner's mailbox, the partner's interrupt goes active. The owner drops its own interrupt by reading its own mailbox. The block watches each port's access strobe, read/write flag, address and busy flag. It drives one registered, active-low interrupt per port.

The mailbox data itself sits in the memory array and is not part of this block. Arbitration is also outside the block: the block only consumes the busy flag that arbitration produces. A port that is being held off by busy can neither raise its partner's interrupt nor drop its own. After reset both interrupts are pending, so software has to read each mailbox once to start from a clean state.

Top module: `mbx_irq`

## Requirements
- R1: With address width W, the right port's mailbox is at 2^W-1 (all ones) and the left port's mailbox is at 2^W-2. The left port is index 0 and the right port is index 1.
- R2: When the left port makes an unblocked write to the right mailbox, `r_irq_n` is low after the next clock edge.
- R3: When the right port makes an unblocked write to the left mailbox, `l_irq_n` is low after the next clock edge.
- R4: When a port makes an unblocked read of its own mailbox, its interrupt output is high after the next clock edge, unless R9 applies.
- R5: A read by a port of its partner's mailbox leaves both interrupt outputs unchanged.
- R6: A write by a port to its own mailbox leaves both interrupt outputs unchanged. So does any access to an address that is not a mailbox.
- R7: While a port's busy flag is high, its accesses neither raise its partner's interrupt nor clear its own.
- R8: While `rst_n` is low at a clock edge, both interrupt outputs go low (pending).
- R9: If the same interrupt is both raised and cleared in one cycle, it ends up low (pending).
- R10: A cycle with the strobe low is not an access, whatever the other inputs of that port hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_stb | input | 1 | Left port access strobe, one cycle per access |
| l_wr | input | 1 | Left port access is a write (1) or read (0) |
| l_addr | input | ADDR_W | Left port access address |
| l_busy | input | 1 | Left port is held off by arbitration |
| r_stb | input | 1 | Right port access strobe |
| r_wr | input | 1 | Right port access is a write (1) or read (0) |
| r_addr | input | ADDR_W | Right port access address |
| r_busy | input | 1 | Right port is held off by arbitration |
| l_irq_n | output | 1 | Left port interrupt, active low, registered |
| r_irq_n | output | 1 | Right port interrupt, active low, registered |

## Verification
With a 3-bit address, the bench sweeps every combination of strobe, direction, busy and address on both ports, starting from all four interrupt states. This covers the confusing cases:
- A port reading its partner's mailbox. A decoder that matched on address alone would clear the wrong interrupt.
- A port writing its own mailbox. A decoder that ignored direction would raise its own interrupt.
- A busy port. If busy were not gated, the port would still set its partner's interrupt or clear its own.
- A raise and a clear of the same interrupt in the same cycle. A design with clear priority would drop a fresh message here.
- The reset value. A design that reset to idle would hide messages that software expects to find pending.

// File: rtl/mbx_irq_pkg.sv
// Package: shared constants for the mailbox interrupt block.
// Assumes exactly two ports, index 0 = left, index 1 = right.
package mbx_irq_pkg;
    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

    // Distance of a port's mailbox below the all-ones address (R1).
    function automatic int unsigned mbx_offset(input int unsigned owner);
        return (owner == PORT_R) ? 0 : 1;
    endfunction
endpackage

// File: rtl/mbx_port_decode.sv
// Module: per-port access decoder.
// Turns one port's access into two events:
//   - a request to clear this port's own interrupt (read of its own mailbox);
//   - a request to raise the partner's interrupt (write to the partner's mailbox).
// Assumes the strobe is high for exactly one cycle per access.
// Busy suppresses both events.
module mbx_port_decode
    import mbx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned OWNER  = PORT_L
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic              wr_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              own_rd_o,
    output logic              peer_wr_o
);
    localparam int unsigned     PEER      = NUM_PORTS - 1 - OWNER;
    localparam logic [ADDR_W-1:0] ALL_ONES  = {ADDR_W{1'b1}};
    // R1: mailbox addresses derived from the address width
    localparam logic [ADDR_W-1:0] OWN_ADDR  = ALL_ONES - ADDR_W'(mbx_offset(OWNER));
    localparam logic [ADDR_W-1:0] PEER_ADDR = ALL_ONES - ADDR_W'(mbx_offset(PEER));

    logic granted;

    // Purpose: an access only counts when strobed and not held off by busy (R7, R10).
    always_comb begin
        granted   = stb_i && !busy_i;
        own_rd_o  = granted && !wr_i && (addr_i == OWN_ADDR);
        peer_wr_o = granted &&  wr_i && (addr_i == PEER_ADDR);
    end

    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (!own_rd_o && !peer_wr_o));
    p_read_never_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |-> !peer_wr_o);
    p_idle_no_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |-> (!own_rd_o && !peer_wr_o));
endmodule

// File: rtl/mbx_irq_flag.sv
// Module: one interrupt state bit with a registered active-low output.
// A raise wins over a clear in the same cycle.
// Reset leaves the interrupt pending.
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    // Purpose: hold the interrupt; reset pending (R8), set priority (R9).
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n_o <= 1'b0;
        else if (set_i)
            irq_n_o <= 1'b0;
        else if (clr_i)
            irq_n_o <= 1'b1;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n_o);
    p_clear_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n_o);
    p_hold_when_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/mbx_irq.sv
// Module: top of the inter-port mailbox interrupt logic.
// Each port has one decoder. Each interrupt flag is raised by the partner's
// decoder and cleared by the owner's decoder. Mailbox storage and
// arbitration live outside this block.
module mbx_irq
    import mbx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_stb,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy,
    input  logic              r_stb,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    logic [NUM_PORTS-1:0] stb_v, wr_v, busy_v, clr_v, peer_set_v, irq_n_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];

    // Purpose: gather the port pins into indexed vectors.
    always_comb begin
        stb_v          = {r_stb, l_stb};
        wr_v           = {r_wr, l_wr};
        busy_v         = {r_busy, l_busy};
        addr_v[PORT_L] = l_addr;
        addr_v[PORT_R] = r_addr;
        l_irq_n        = irq_n_v[PORT_L];
        r_irq_n        = irq_n_v[PORT_R];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbx_port_decode #(
            .ADDR_W (ADDR_W),
            .OWNER  (p)
        ) i_dec (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb_i     (stb_v[p]),
            .wr_i      (wr_v[p]),
            .busy_i    (busy_v[p]),
            .addr_i    (addr_v[p]),
            .own_rd_o  (clr_v[p]),
            .peer_wr_o (peer_set_v[p])
        );

        // R2/R3: the partner's write raises this port's flag.
        mbx_irq_flag i_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (peer_set_v[NUM_PORTS-1-p]),
            .clr_i   (clr_v[p]),
            .irq_n_o (irq_n_v[p])
        );
    end
endmodule

// File: tb/test_mbx_irq.sv
module test_mbx_irq;
    localparam int unsigned AW = 3;
    localparam logic [AW-1:0] MB_R = 3'd7;   // R1
    localparam logic [AW-1:0] MB_L = 3'd6;   // R1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_stb = 0, l_wr = 0, l_busy = 0, r_stb = 0, r_wr = 0, r_busy = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mbx_irq #(.ADDR_W(AW)) i_mbx_irq (
        .clk(clk), .rst_n(rst_n),
        .l_stb(l_stb), .l_wr(l_wr), .l_addr(l_addr), .l_busy(l_busy),
        .r_stb(r_stb), .r_wr(r_wr), .r_addr(r_addr), .r_busy(r_busy),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        l_stb = 0; l_wr = 0; l_busy = 0; l_addr = '0;
        r_stb = 0; r_wr = 0; r_busy = 0; r_addr = '0;
    endtask

    // Requirement tag for a given flag's outcome in a sweep vector.
    function automatic string tag_for(input int f, input logic setf, input logic clrf,
                                      input logic [5:0] vl, input logic [5:0] vr);
        if (setf && clrf) return "R9";
        if (setf) return (f == 1) ? "R2" : "R3";
        if (clrf) return "R4";
        if (!vl[5] && !vr[5]) return "R10";
        if ((vl[5] && vl[3]) || (vr[5] && vr[3])) return "R7";
        if ((vl[5] && !vl[4] && vl[2:0] == MB_R) || (vr[5] && !vr[4] && vr[2:0] == MB_L))
            return "R5";
        return "R6";
    endfunction

    initial begin
        idle();
        // R8: reset state
        @(negedge clk); @(negedge clk);
        check("R8", "l_irq_n after reset", l_irq_n, 1'b0);
        check("R8", "r_irq_n after reset", r_irq_n, 1'b0);
        // R1: each owner clears at its own mailbox address
        rst_n = 1;
        l_stb = 1; l_addr = MB_L; r_stb = 1; r_addr = MB_R;
        @(negedge clk); idle();
        check("R1", "l_irq_n after own read", l_irq_n, 1'b1);
        check("R1", "r_irq_n after own read", r_irq_n, 1'b1);

        // Exhaustive sweep: start state x left vector x right vector.
        // Vector bits: [5] strobe, [4] write, [3] busy, [2:0] address.
        for (int st = 0; st < 4; st++) begin
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    logic [5:0] vl, vr;
                    logic gl, gr, set0, clr0, set1, clr1, p0, p1;
                    vl = 6'(a); vr = 6'(b);
                    @(negedge clk); rst_n = 0; idle();
                    @(negedge clk); rst_n = 1;
                    l_stb = !st[0]; l_addr = MB_L;
                    r_stb = !st[1]; r_addr = MB_R;
                    @(negedge clk);
                    l_stb = vl[5]; l_wr = vl[4]; l_busy = vl[3]; l_addr = vl[2:0];
                    r_stb = vr[5]; r_wr = vr[4]; r_busy = vr[3]; r_addr = vr[2:0];
                    @(negedge clk); idle();
                    gl = vl[5] && !vl[3];
                    gr = vr[5] && !vr[3];
                    set0 = gr && vr[4] && (vr[2:0] == MB_L);
                    clr0 = gl && !vl[4] && (vl[2:0] == MB_L);
                    set1 = gl && vl[4] && (vl[2:0] == MB_R);
                    clr1 = gr && !vr[4] && (vr[2:0] == MB_R);
                    p0 = set0 ? 1'b1 : (clr0 ? 1'b0 : 1'(st[0]));
                    p1 = set1 ? 1'b1 : (clr1 ? 1'b0 : 1'(st[1]));
                    check(tag_for(0, set0, clr0, vl, vr),
                          $sformatf("l_irq_n st=%0d l=%02h r=%02h", st, vl, vr), l_irq_n, !p0);
                    check(tag_for(1, set1, clr1, vl, vr),
                          $sformatf("r_irq_n st=%0d l=%02h r=%02h", st, vl, vr), r_irq_n, !p1);
                end
            end
        end
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(150000 * 4);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule